// File: doc/BRIEF.md
# Serial Frame Sniffer Output

This block copies the bytes of radio frames onto a two-wire debug port made of a slow serial clock and a data line, so an external logic analyser or a plain SPI slave can record every frame. It has a third output, a registered copy of the start-of-frame-delimiter flag, which lets the capture be time stamped. A byte tap (valid, byte, last-of-frame) feeds the block. When the radio is transmitting, this tap carries the bytes the modulator reads. When the radio is receiving, it carries the bytes the demodulator stores.

A small staging register and a short FIFO sit between the tap and the serialiser. The staging register holds one byte back, so the block knows which two bytes end a frame. In transmit mode with automatic checksum generation, those two closing bytes are replaced by the marker 0x80 0x80. Received frames are never altered. A listener can therefore tell frames the radio sent from frames it received. A divider derives the serial clock from the system clock. The default divider gives 250 kHz from a 32 MHz system clock.

Top module: `pkt_sniffer`

## Requirements
- R1: After reset, snf_clk, snf_dat, snf_sfd and ovf are all low.
- R2: Each byte is sent most significant bit first. The listener takes one bit on each rising edge of snf_clk. snf_dat changes only while snf_clk is low.
- R3: Each bit is DIV_HALF system cycles of low snf_clk followed by DIV_HALF cycles of high snf_clk. Back-to-back bits therefore have rising edges 2*DIV_HALF cycles apart. snf_clk rests low when no byte is queued.
- R4: With tx_mode=1 and auto_crc=0, every tapped byte is sent unchanged and in arrival order.
- R5: With tx_mode=1 and auto_crc=1, the byte tapped with tap_last=1 and the byte just before it are each sent as 0x80. All earlier bytes of the frame are sent unchanged.
- R6: With tx_mode=0, every byte is sent unchanged, including the last two, whatever auto_crc is.
- R7: snf_sfd equals sfd_in AND snf_en as sampled one system cycle earlier.
- R8: While snf_en is low, tapped bytes are ignored, snf_clk and snf_dat stay low, and a byte being sent is abandoned. Clearing snf_en also clears ovf. After snf_en rises again, the next frame is sent intact.
- R9: A byte offered to a full FIFO (BUF_DEPTH entries) is dropped and ovf goes high. ovf stays high until snf_en is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snf_en | input | 1 | Sniffer enable |
| tx_mode | input | 1 | 1: tap carries transmitted bytes, 0: received bytes |
| auto_crc | input | 1 | Automatic checksum generation is on |
| sfd_in | input | 1 | Start-of-frame-delimiter flag from the radio |
| tap_vld | input | 1 | Tap byte valid, one cycle per byte |
| tap_byte | input | 8 | Tapped byte |
| tap_last | input | 1 | Tapped byte is the last of its frame |
| snf_clk | output | 1 | Sniffer serial clock |
| snf_dat | output | 1 | Sniffer serial data |
| snf_sfd | output | 1 | Registered start-of-frame-delimiter strobe |
| ovf | output | 1 | Sticky FIFO overflow flag |

## Verification
The bench builds the block with DIV_HALF=2 and BUF_DEPTH=4. At that divider a byte takes 32 system cycles, so whole frames, the divider period and an abandoned byte all fit into short tests. With a four-entry FIFO, a burst of ten back-to-back tap bytes fills the FIFO. The bench can then predict exactly which five bytes survive and check that the overflow flag stays set.

// File: rtl/pkt_snf_pkg.sv
package pkt_snf_pkg;
  typedef enum logic [1:0] {
    SER_IDLE = 2'd0,
    SER_LOW  = 2'd1,
    SER_HIGH = 2'd2
  } ser_state_e;

  localparam logic [7:0] CRC_MARK = 8'h80;
endpackage

// File: rtl/pkt_snf_stage.sv
// Holds one byte back so the two closing bytes of a frame are known when pushed.
module pkt_snf_stage
  import pkt_snf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       subst,
  input  logic       tap_vld,
  input  logic [7:0] tap_byte,
  input  logic       tap_last,
  output logic       push,
  output logic [7:0] push_byte
);
  logic       stg_v_q, stg_v_d;
  logic [7:0] stg_b_q, stg_b_d;
  logic       stg_l_q, stg_l_d;
  logic       mark;

  always_comb begin
    push      = stg_v_q && (tap_vld || stg_l_q) && !clr;
    mark      = subst && (stg_l_q || (tap_vld && tap_last));
    push_byte = mark ? CRC_MARK : stg_b_q;
    stg_v_d   = stg_v_q;
    stg_b_d   = stg_b_q;
    stg_l_d   = stg_l_q;
    if (clr) begin
      stg_v_d = 1'b0;
      stg_b_d = 8'h00;
      stg_l_d = 1'b0;
    end else if (tap_vld) begin
      stg_v_d = 1'b1;
      stg_b_d = tap_byte;
      stg_l_d = tap_last;
    end else if (push) begin
      stg_v_d = 1'b0;
      stg_l_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_v_q <= 1'b0;
      stg_b_q <= 8'h00;
      stg_l_q <= 1'b0;
    end else begin
      stg_v_q <= stg_v_d;
      stg_b_q <= stg_b_d;
      stg_l_q <= stg_l_d;
    end
  end
endmodule

// File: rtl/pkt_snf_fifo.sv
module pkt_snf_fifo #(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic [7:0] din,
  input  logic       pop,
  output logic [7:0] dout,
  output logic       avail,
  output logic       full,
  output logic       ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ovf_q, ovf_d;
  logic          wr_en, rd_en;

  always_comb begin
    full  = (cnt_q == CW'(DEPTH));
    avail = (cnt_q != '0);
    dout  = mem[rd_q];
    wr_en = push && !full && !clr;
    rd_en = pop && avail && !clr;
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (wr_en) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (rd_en) rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (wr_en && !rd_en) cnt_d = cnt_q + 1'b1;
    else if (rd_en && !wr_en) cnt_d = cnt_q - 1'b1;
    if (push && full) ovf_d = 1'b1;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      cnt_d = '0;
      ovf_d = 1'b0;
    end
    ovf = ovf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_q] <= din;
  end
endmodule

// File: rtl/pkt_snf_ser.sv
// MSB-first serialiser; data moves on the falling clock edge, clock rests low.
module pkt_snf_ser
  import pkt_snf_pkg::*;
#(
  parameter int DIV_HALF = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       avail,
  input  logic [7:0] byte_in,
  output logic       pop,
  output logic       sclk,
  output logic       sdat
);
  localparam int DW = $clog2(DIV_HALF + 1);

  ser_state_e    st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    shr_q, shr_d;
  logic          tick;

  always_comb begin
    tick  = (cnt_q == DW'(DIV_HALF - 1));
    st_d  = st_q;
    cnt_d = cnt_q;
    bit_d = bit_q;
    shr_d = shr_q;
    pop   = 1'b0;
    case (st_q)
      SER_IDLE: begin
        if (avail) begin
          pop   = 1'b1;
          shr_d = byte_in;
          bit_d = 3'd0;
          cnt_d = '0;
          st_d  = SER_LOW;
        end
      end
      SER_LOW: begin
        if (tick) begin
          cnt_d = '0;
          st_d  = SER_HIGH;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      SER_HIGH: begin
        if (tick) begin
          cnt_d = '0;
          if (bit_q == 3'd7) begin
            if (avail) begin
              pop   = 1'b1;
              shr_d = byte_in;
              bit_d = 3'd0;
              st_d  = SER_LOW;
            end else begin
              shr_d = 8'h00;
              st_d  = SER_IDLE;
            end
          end else begin
            shr_d = {shr_q[6:0], 1'b0};
            bit_d = bit_q + 1'b1;
            st_d  = SER_LOW;
          end
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = SER_IDLE;
    endcase
    if (clr) begin
      pop   = 1'b0;
      st_d  = SER_IDLE;
      cnt_d = '0;
      bit_d = 3'd0;
      shr_d = 8'h00;
    end
    sclk = (st_q == SER_HIGH);
    sdat = (st_q != SER_IDLE) && shr_q[7];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SER_IDLE;
      cnt_q <= '0;
      bit_q <= 3'd0;
      shr_q <= 8'h00;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bit_q <= bit_d;
      shr_q <= shr_d;
    end
  end
endmodule

// File: rtl/pkt_sniffer.sv
module pkt_sniffer #(
  parameter int DIV_HALF  = 64,
  parameter int BUF_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       snf_en,
  input  logic       tx_mode,
  input  logic       auto_crc,
  input  logic       sfd_in,
  input  logic       tap_vld,
  input  logic [7:0] tap_byte,
  input  logic       tap_last,
  output logic       snf_clk,
  output logic       snf_dat,
  output logic       snf_sfd,
  output logic       ovf
);
  logic       clr;
  logic       subst;
  logic       stg_push;
  logic [7:0] stg_byte;
  logic [7:0] buf_head;
  logic       buf_avail;
  logic       buf_full;
  logic       ser_pop;
  logic       sfd_q, sfd_d;

  assign clr   = !snf_en;
  assign subst = tx_mode && auto_crc;

  pkt_snf_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .subst     (subst),
    .tap_vld   (tap_vld),
    .tap_byte  (tap_byte),
    .tap_last  (tap_last),
    .push      (stg_push),
    .push_byte (stg_byte)
  );

  pkt_snf_fifo #(.DEPTH(BUF_DEPTH)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .push  (stg_push),
    .din   (stg_byte),
    .pop   (ser_pop),
    .dout  (buf_head),
    .avail (buf_avail),
    .full  (buf_full),
    .ovf   (ovf)
  );

  pkt_snf_ser #(.DIV_HALF(DIV_HALF)) u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .avail   (buf_avail),
    .byte_in (buf_head),
    .pop     (ser_pop),
    .sclk    (snf_clk),
    .sdat    (snf_dat)
  );

  always_comb sfd_d = sfd_in && snf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sfd_q <= 1'b0;
    else        sfd_q <= sfd_d;
  end

  assign snf_sfd = sfd_q;
endmodule

// File: rtl/pkt_sniffer_chk.sv
module pkt_sniffer_chk #(
  parameter int DIV_HALF = 64
) (
  input logic clk,
  input logic rst_n,
  input logic snf_en,
  input logic sfd_in,
  input logic snf_clk,
  input logic snf_dat,
  input logic snf_sfd,
  input logic ovf,
  input logic push,
  input logic full
);
  logic [15:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= 16'd0;
    else if (snf_clk) hi_len <= hi_len + 16'd1;
    else              hi_len <= 16'd0;
  end

  AST_DAT_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    snf_clk |-> $stable(snf_dat)); // R2

  AST_HIGH_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    hi_len <= 16'(DIV_HALF)); // R3

  AST_SFD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sfd_in && snf_en) |=> snf_sfd); // R7

  AST_QUIET_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !snf_en |=> (!snf_clk && !snf_dat && !ovf)); // R8

  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && snf_en) |=> ovf); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && snf_en) |=> ovf); // R9
endmodule

bind pkt_sniffer pkt_sniffer_chk #(.DIV_HALF(DIV_HALF)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .snf_en  (snf_en),
  .sfd_in  (sfd_in),
  .snf_clk (snf_clk),
  .snf_dat (snf_dat),
  .snf_sfd (snf_sfd),
  .ovf     (ovf),
  .push    (stg_push),
  .full    (buf_full)
);

// File: tb/pkt_sniffer_tb.sv
module pkt_sniffer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;
  localparam int BUF_DEPTH  = 4;
  localparam int BYTE_GAP   = 16 * DIV_HALF + 8;

  logic       clk, rst_n, snf_en, tx_mode, auto_crc, sfd_in;
  logic       tap_vld, tap_last;
  logic [7:0] tap_byte;
  logic       snf_clk, snf_dat, snf_sfd, ovf;

  int n_chk, n_fail;
  bit done;

  logic [7:0] frm [16];
  int         frm_n;
  logic [7:0] cap [32];
  int         cap_n;
  logic [7:0] sh;
  int         bc;
  int         since_rise, min_per;
  logic       clk_prev;

  pkt_sniffer #(.DIV_HALF(DIV_HALF), .BUF_DEPTH(BUF_DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .snf_en(snf_en), .tx_mode(tx_mode),
    .auto_crc(auto_crc), .sfd_in(sfd_in), .tap_vld(tap_vld),
    .tap_byte(tap_byte), .tap_last(tap_last), .snf_clk(snf_clk),
    .snf_dat(snf_dat), .snf_sfd(snf_sfd), .ovf(ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  // external listener: one bit per rising edge of the sniffer clock
  always @(posedge snf_clk) begin
    sh = {sh[6:0], snf_dat};
    bc = bc + 1;
    if (bc == 8) begin
      if (cap_n < 32) cap[cap_n] = sh;
      cap_n = cap_n + 1;
      bc = 0;
    end
  end

  // shortest rise-to-rise distance in system cycles
  always @(posedge clk) begin
    since_rise = since_rise + 1;
    if (snf_clk && !clk_prev) begin
      if (since_rise < min_per) min_per = since_rise;
      since_rise = 0;
    end
    clk_prev = snf_clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cap_clear();
    cap_n = 0;
    bc = 0;
    sh = 8'h00;
    since_rise = 0;
    min_per = 1000;
  endtask

  task automatic send_frame(input int gap);
    for (int i = 0; i < frm_n; i++) begin
      @(negedge clk);
      tap_vld  = 1'b1;
      tap_byte = frm[i];
      tap_last = (i == frm_n - 1);
      @(negedge clk);
      tap_vld  = 1'b0;
      tap_last = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  task automatic load5();
    frm[0] = 8'hA1; frm[1] = 8'hB2; frm[2] = 8'hC3;
    frm[3] = 8'hD4; frm[4] = 8'hE5;
    frm_n = 5;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 snf_clk", int'(snf_clk), 0);
    chk("R1 snf_dat", int'(snf_dat), 0);
    chk("R1 snf_sfd", int'(snf_sfd), 0);
    chk("R1 ovf", int'(ovf), 0);
  endtask

  task automatic t_tx_plain();
    cap_clear();
    tx_mode = 1'b1; auto_crc = 1'b0;
    load5();
    send_frame(BYTE_GAP);
    repeat (BYTE_GAP) @(negedge clk);
    chk("R4 count", cap_n, 5);
    for (int i = 0; i < 5; i++) chk("R4 byte (R2 msb first)", int'(cap[i]), int'(frm[i]));
    chk("R3 idle clock low", int'(snf_clk), 0);
  endtask

  task automatic t_tx_crc();
    cap_clear();
    tx_mode = 1'b1; auto_crc = 1'b1;
    load5();
    send_frame(BYTE_GAP);
    repeat (BYTE_GAP) @(negedge clk);
    chk("R5 count", cap_n, 5);
    chk("R5 byte0", int'(cap[0]), 'hA1);
    chk("R5 byte2", int'(cap[2]), 'hC3);
    chk("R5 marker1", int'(cap[3]), 'h80);
    chk("R5 marker2", int'(cap[4]), 'h80);
  endtask

  task automatic t_rx();
    cap_clear();
    tx_mode = 1'b0; auto_crc = 1'b1;
    load5();
    send_frame(BYTE_GAP);
    repeat (BYTE_GAP) @(negedge clk);
    chk("R6 count", cap_n, 5);
    chk("R6 crc byte1", int'(cap[3]), 'hD4);
    chk("R6 crc byte2", int'(cap[4]), 'hE5);
  endtask

  task automatic t_period();
    cap_clear();
    tx_mode = 1'b0; auto_crc = 1'b0;
    frm[0] = 8'h3C; frm[1] = 8'h96; frm_n = 2;
    send_frame(0);
    repeat (3 * BYTE_GAP) @(negedge clk);
    chk("R3 bit period", min_per, 2 * DIV_HALF);
    chk("R2 back-to-back byte0", int'(cap[0]), 'h3C);
    chk("R2 back-to-back byte1", int'(cap[1]), 'h96);
  endtask

  task automatic t_sfd();
    @(negedge clk); sfd_in = 1'b1;
    @(negedge clk);
    chk("R7 sfd high", int'(snf_sfd), 1);
    sfd_in = 1'b0;
    @(negedge clk);
    chk("R7 sfd low", int'(snf_sfd), 0);
    snf_en = 1'b0; sfd_in = 1'b1;
    @(negedge clk);
    chk("R7 sfd gated", int'(snf_sfd), 0);
    sfd_in = 1'b0; snf_en = 1'b1;
  endtask

  task automatic t_disable();
    cap_clear();
    snf_en = 1'b0;
    tx_mode = 1'b0;
    load5();
    send_frame(4);
    repeat (BYTE_GAP) @(negedge clk);
    chk("R8 nothing sent", cap_n, 0);
    chk("R8 clock low", int'(snf_clk), 0);
    // abandon a byte in flight
    snf_en = 1'b1;
    frm[0] = 8'hFF; frm_n = 1;
    send_frame(10);
    snf_en = 1'b0;
    @(negedge clk);
    chk("R8 abort clk", int'(snf_clk), 0);
    chk("R8 abort dat", int'(snf_dat), 0);
    snf_en = 1'b1;
    cap_clear();
    frm[0] = 8'h5A; frm_n = 1;
    send_frame(BYTE_GAP);
    chk("R8 resume count", cap_n, 1);
    chk("R8 resume byte", int'(cap[0]), 'h5A);
  endtask

  task automatic t_overflow();
    cap_clear();
    tx_mode = 1'b0; auto_crc = 1'b0;
    for (int i = 0; i < 10; i++) frm[i] = 8'(8'h10 + i);
    frm_n = 10;
    for (int i = 0; i < frm_n; i++) begin
      @(negedge clk);
      tap_vld = 1'b1; tap_byte = frm[i]; tap_last = (i == frm_n - 1);
    end
    @(negedge clk);
    tap_vld = 1'b0; tap_last = 1'b0;
    @(negedge clk);
    chk("R9 ovf set", int'(ovf), 1);
    repeat (7 * BYTE_GAP) @(negedge clk);
    chk("R9 kept bytes", cap_n, 5);
    for (int i = 0; i < 5; i++) chk("R9 kept byte", int'(cap[i]), int'(frm[i]));
    chk("R9 ovf sticky", int'(ovf), 1);
    snf_en = 1'b0;
    @(negedge clk);
    chk("R8 ovf cleared", int'(ovf), 0);
    snf_en = 1'b1;
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0;
    clk_prev = 1'b0;
    cap_clear();
    rst_n = 1'b0; snf_en = 1'b0; tx_mode = 1'b0; auto_crc = 1'b0;
    sfd_in = 1'b0; tap_vld = 1'b0; tap_byte = 8'h00; tap_last = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    snf_en = 1'b1;
    t_tx_plain();
    t_tx_crc();
    t_rx();
    t_period();
    t_sfd();
    t_disable();
    t_overflow();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule